// File: doc/BRIEF.md
# Modulo Timer with Guarded Overflow Flag

A 16-bit up-counter fed by a power-of-two prescaler. The counter climbs from zero to a programmable limit and, on the next prescaler tick, returns to zero and raises an overflow flag. When the matching enable is set, the flag drives an interrupt request. A three-word register window holds the control and status word, the live count and the limit, accessed with plain read and write strobes.

The flag cannot be dropped by accident. Software first reads the control word while the flag is 1, then writes a 0 to the flag bit. A new overflow that lands at or after that read cancels the pending clear, so an event is never lost.

The timer leaves reset halted. A write-only restart bit zeroes the counter and the prescaler. Writing halt and restart together parks the counter at zero.

Top module: `modtimer`

## Requirements
- R1: After reset the control word (address 0) reads 0x0020: halt is 1 and every other field is 0. The count (address 1) reads 0x0000, the limit (address 2) reads 0xFFFF, and irq is 0.
- R2: Control word bits [2:0] choose the prescale exponent s. A value of 0 to 6 divides by 2^s, and the value 7 behaves as 6. The counter advances once every 2^s clocks. Counter and prescaler both freeze while halt (bit 5) is 1.
- R3: When a tick arrives while the count equals the limit, the count returns to 0x0000 and the flag (bit 7) becomes 1 on that same edge. The counter therefore runs through 0 to limit.
- R4: A write of 0 to bit 7 clears the flag only if the most recent control-word access was a read that saw the flag at 1. A 0 written without such a read leaves the flag at 1. A 1 written to bit 7 never changes it.
- R5: An overflow that occurs in the same cycle as the qualifying read, or any time after it, cancels that qualification. A later write of 0 to bit 7 then leaves the flag set, including when that write falls in the overflow cycle itself.
- R6: irq is 1 exactly when the flag is 1 and the interrupt enable (bit 6) is 1.
- R7: Writing 1 to restart (bit 4) zeroes the counter and the prescaler on that write's edge. Counting then resumes from 0x0000. Bit 4 always reads 0, and neither the limit nor the flag changes.
- R8: A single control write that sets both halt and restart holds the count at 0x0000 for as long as halt stays 1.
- R9: The count (address 1) and the limit (address 2) can be read and written. Writing the limit leaves the current count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, takes effect on the rising edge |
| rd_en | input | 1 | Read strobe, which qualifies the flag clear when the address is 0 |
| addr | input | 2 | Register select: 0 is control, 1 is count, 2 is limit |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hard coincidence is a counter wrap that lands on the same edge as the write that would clear the flag. This case also extends to a wrap falling between the qualifying read and that write. The bench restarts the counter at a known edge with a limit of 3 and no prescaling, then reads the control word one edge later. It places the clearing write on exactly the fourth edge, so the wrap and the clear meet. The flag must stay at 1 there, while the same sequence with the write moved before the wrap must clear it. A third run with a limit of 7 puts the wrap between the read and the write and again expects the flag to survive.

// File: rtl/modtimer.sv
module modtimer #(
  parameter int CW   = 16,
  parameter int AW   = 2,
  parameter int SELW = 3,
  parameter int PREW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam logic [AW-1:0] A_MOD  = AW'(2);
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_HALT = 5;
  localparam int B_RST  = 4;
  localparam logic [SELW-1:0] SEL_MAX = SELW'(PREW);

  logic [CW-1:0]   cnt, modv;
  logic [PREW-1:0] pre, pmask;
  logic [SELW-1:0] sel, sel_eff;
  logic            flag, ie, halt, armed;
  logic            wr_ctrl, rd_ctrl, wr_cnt, wr_mod, restart;
  logic            tick, wrap, ovf_ev, clr_ev;

  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_cnt  = wr_en && addr == A_CNT;
  assign wr_mod  = wr_en && addr == A_MOD;
  assign rd_ctrl = rd_en && addr == A_CTRL;
  assign restart = wr_ctrl && wdata[B_RST];

  assign sel_eff = (sel > SEL_MAX) ? SEL_MAX : sel;
  assign pmask   = ~({PREW{1'b1}} << sel_eff);
  assign tick    = !halt && ((pre & pmask) == pmask);
  assign wrap    = tick && cnt == modv;
  assign ovf_ev  = wrap && !restart && !wr_cnt;
  assign clr_ev  = wr_ctrl && !wdata[B_FLAG] && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (restart) pre <= '0;
    else if (!halt) pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= '0;
    else if (wr_cnt) cnt <= wdata;
    else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modv <= '1;
    else if (wr_mod) modv <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      halt <= 1'b1;
      sel  <= '0;
    end else if (wr_ctrl) begin
      ie   <= wdata[B_IE];
      halt <= wdata[B_HALT];
      sel  <= wdata[SELW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (ovf_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (ovf_ev || wr_ctrl) armed <= 1'b0;
    else if (rd_ctrl && flag) armed <= 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[B_FLAG]   = flag;
        rdata[B_IE]     = ie;
        rdata[B_HALT]   = halt;
        rdata[SELW-1:0] = sel;
      end
      A_CNT:   rdata = cnt;
      A_MOD:   rdata = modv;
      default: rdata = '0;
    endcase
  end

  assign irq = flag && ie;
endmodule

module modtimer_chk #(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] wdata,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] modv,
  input logic          flag,
  input logic          ie,
  input logic          halt,
  input logic          armed,
  input logic          tick
);
  a_r2_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !wr_en |=> $stable(cnt));

  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == modv && !wr_en |=> cnt == '0 && flag);

  a_r4_unarmed_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !armed && wr_en && addr == '0 |=> flag);

  a_r4_one_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag && wr_en && addr == '0 && wdata[7] |=> flag);

  a_r5_overflow_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == modv && !wr_en |=> !armed);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie && flag);

  a_r7_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == '0 && wdata[4] |=> cnt == '0);

  a_r9_limit_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(2) && !tick |=> $stable(cnt));
endmodule

bind modtimer modtimer_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .cnt(cnt), .modv(modv), .flag(flag), .ie(ie), .halt(halt),
  .armed(armed), .tick(tick)
);

// File: tb/sim_modtimer.sv
module sim_modtimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  localparam logic [15:0] FLAG = 16'h0080;
  localparam logic [15:0] IE   = 16'h0040;
  localparam logic [15:0] HALT = 16'h0020;
  localparam logic [15:0] RST  = 16'h0010;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  modtimer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
               .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic clear_flag();
    logic [15:0] v;
    wr(2'd0, HALT | RST);
    rd(2'd0, v);
    wr(2'd0, HALT);
  endtask

  initial begin
    logic [15:0] v;
    int se, n, lim, ticks;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    peek(2'd0, v); check("R1 ctrl", v, 16'h0020);
    peek(2'd1, v); check("R1 count", v, 0);
    peek(2'd2, v); check("R1 limit", v, 16'hFFFF);
    check("R1 irq", irq, 0);

    for (int s = 0; s < 8; s++) begin
      for (int mi = 0; mi < 2; mi++) begin
        int m;
        m = (mi == 0) ? 1 : 4;
        se = (s > 6) ? 6 : s;
        clear_flag();
        wr(2'd2, 16'(m));
        wr(2'd0, RST | 16'(s));
        n = 0;
        lim = 3 * (m + 1) * (1 << se) + 5;
        while (n < lim) begin
          idle(23);
          n = n + 23;
          ticks = n >> se;
          peek(2'd1, v); check("R2 R3 sweep count", v, ticks % (m + 1));
          peek(2'd0, v); check("R3 sweep flag", v[7], (ticks >= m + 1) ? 1 : 0);
        end
      end
    end

    wr(2'd2, 16'd1000);
    wr(2'd0, RST);
    idle(50);
    peek(2'd1, v); check("R2 running", v, 50);
    wr(2'd0, HALT);
    idle(30);
    peek(2'd1, v); check("R2 halted count", v, 51);
    wr(2'd0, 16'h0000);
    idle(9);
    peek(2'd1, v); check("R2 resumed count", v, 60);

    wr(2'd0, RST | 16'd2);
    idle(6);
    peek(2'd1, v); check("R2 prescale before halt", v, 1);
    wr(2'd0, HALT | 16'd2);
    idle(20);
    peek(2'd1, v); check("R2 prescale frozen", v, 1);
    wr(2'd0, 16'd2);
    peek(2'd1, v); check("R2 prescale resume edge", v, 1);
    idle(1);
    peek(2'd1, v); check("R2 prescale kept phase", v, 2);

    clear_flag();
    wr(2'd0, RST);
    idle(40);
    peek(2'd1, v); check("R7 before restart", v, 40);
    wr(2'd0, RST);
    peek(2'd1, v); check("R7 zeroed", v, 0);
    idle(5);
    peek(2'd1, v); check("R7 resumes from zero", v, 5);
    peek(2'd0, v); check("R7 restart reads zero", v, 16'h0000);
    peek(2'd2, v); check("R7 limit kept", v, 1000);

    wr(2'd0, HALT | RST);
    idle(100);
    peek(2'd1, v); check("R8 parked", v, 0);

    wr(2'd1, 16'd1234);
    peek(2'd1, v); check("R9 count write", v, 1234);
    wr(2'd2, 16'd77);
    peek(2'd1, v); check("R9 limit write keeps count", v, 1234);
    peek(2'd2, v); check("R9 limit readback", v, 77);
    wr(2'd2, 16'd1000);
    wr(2'd0, RST);
    idle(10);
    wr(2'd2, 16'd500);
    peek(2'd1, v); check("R9 running limit write", v, 11);

    wr(2'd2, 16'd3);
    wr(2'd0, RST);
    idle(10);
    wr(2'd0, HALT);
    peek(2'd0, v); check("R4 unread zero keeps flag", v[7], 1);
    rd(2'd0, v);
    wr(2'd0, HALT | FLAG);
    peek(2'd0, v); check("R4 one write keeps flag", v[7], 1);
    wr(2'd0, HALT | IE);
    check("R6 irq on", irq, 1);
    wr(2'd0, HALT);
    check("R6 irq off", irq, 0);
    rd(2'd0, v);
    wr(2'd0, HALT);
    peek(2'd0, v); check("R4 handshake clears", v[7], 0);
    wr(2'd0, HALT | FLAG | IE);
    peek(2'd0, v); check("R4 one on clear flag", v[7], 0);
    check("R6 irq needs flag", irq, 0);

    wr(2'd0, RST);
    idle(10);
    wr(2'd0, RST | FLAG);
    rd(2'd0, v);
    idle(2);
    wr(2'd0, HALT);
    peek(2'd0, v); check("R5 overflow same cycle as clear", v[7], 1);

    wr(2'd0, RST | FLAG);
    rd(2'd0, v);
    wr(2'd0, HALT);
    peek(2'd0, v); check("R5 clear before overflow", v[7], 0);

    wr(2'd2, 16'd7);
    wr(2'd0, RST);
    idle(12);
    wr(2'd0, RST | FLAG);
    rd(2'd0, v);
    idle(9);
    wr(2'd0, HALT);
    peek(2'd0, v); check("R5 overflow after read", v[7], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule